// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block serves one core's atomic read-modify-write sequences built from a load-linked (LL) followed by a store-conditional (SC). A request port carries an opcode (idle, plain load, plain store, LL or SC), a byte address and write data. A snoop port reports addresses that other agents are invalidating or writing. The block owns a small backing memory. It answers every request one cycle later with read data and, for an SC, a pass/fail flag.

An LL is an ordinary shared read. It reads the word and arms a single reservation that holds a granule address and a separate valid flag. It causes no ownership traffic of its own. A snoop that hits the reserved granule quietly disarms the reservation. An SC writes memory only if the reservation is still armed for the same granule. Every SC, whether it passes or fails, disarms the reservation. Software retries a failed sequence.

Top module: `llsc_monitor`

## Requirements
- R1: An LL request returns the current memory word on `rsp_rdata` in the cycle after the request and arms the reservation for its granule.
- R2: A plain load returns the memory word the cycle after the request. A plain store writes memory unconditionally and leaves the reservation as it was. Opcode encoding on `req_op`: 0 idle, 1 load, 2 store, 3 LL, 4 SC.
- R3: An SC to the armed granule with no conflicting snoop writes `req_wdata` to memory and reports `rsp_sc_ok`=1 the next cycle.
- R4: A failing SC leaves memory unchanged and reports `rsp_sc_ok`=0.
- R5: A snoop to the reserved granule disarms the reservation. A snoop to any other granule has no effect on it.
- R6: An SC to a granule other than the reserved one fails.
- R7: Every SC disarms the reservation, so a second SC without a new LL fails.
- R8: When a snoop to the reserved granule arrives in the same cycle as an SC, the snoop takes priority and the SC fails.
- R9: Addresses are compared per granule. The low `GRAN_BITS` bits (default 2, one 32-bit word) are ignored.
- R10: Reset leaves the reservation disarmed and `rsp_valid` low. A new LL replaces any earlier reservation. Address 0 can be reserved like any other address.
- R11: An LL that coincides with a snoop to its own granule leaves the reservation disarmed.
- R12: `rsp_valid` is high exactly one cycle after each valid request. `rsp_sc_ok` is high only on the response to an SC. `rsp_rdata` is 0 for responses to anything other than a load or LL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Opcode: 0 idle, 1 load, 2 store, 3 LL, 4 SC |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store / SC data |
| snp_valid | input | 1 | Another agent writes or invalidates `snp_addr` |
| snp_addr | input | ADDR_W | Snooped byte address |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DATA_W | Read data for load / LL |
| rsp_sc_ok | output | 1 | SC succeeded |

## Verification
The bench targets the collisions: a snoop in the same cycle as an SC, and a snoop in the same cycle as an LL. If the design let either one through, the SC would pass and overwrite memory that another agent had just claimed. Back-to-back SCs and an SC to a neighbouring word catch a design that forgets to disarm the reservation or that compares too few address bits. Such a design reports a false success and corrupts memory, which the follow-up loads reveal. Snoops and SCs to other byte offsets inside a word, and a reservation at address 0, expose granule masking errors and the use of address zero as an "empty" marker.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_LL    = 3'd3,
        OP_SC    = 3'd4
    } op_e;

    // Opcodes whose response carries memory data
    function automatic logic op_returns_data(input op_e op);
        return (op == OP_LOAD) || (op == OP_LL);
    endfunction

endpackage

// File: rtl/llsc_resv.sv
module llsc_resv #(
    parameter int ADDR_W    = 16,
    parameter int GRAN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ll_fire,
    input  logic              sc_fire,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              resv_valid,
    output logic              sc_pass
);
    localparam int TAG_W = ADDR_W - GRAN_BITS;

    typedef struct packed {
        logic             armed;
        logic [TAG_W-1:0] tag;
    } resv_t;

    resv_t resv_q, resv_d;

    logic [TAG_W-1:0] req_tag, snp_tag;
    logic             snoop_hits_resv, snoop_hits_req;

    assign req_tag = req_addr[ADDR_W-1:GRAN_BITS];
    assign snp_tag = snp_addr[ADDR_W-1:GRAN_BITS];

    assign snoop_hits_resv = snp_valid && (snp_tag == resv_q.tag);
    assign snoop_hits_req  = snp_valid && (snp_tag == req_tag);

    // A snoop to the reserved granule beats a same-cycle SC
    assign sc_pass = sc_fire && resv_q.armed && (resv_q.tag == req_tag)
                     && !snoop_hits_resv;

    always_comb begin
        resv_d = resv_q;
        if (ll_fire) begin
            resv_d.tag   = req_tag;
            resv_d.armed = !snoop_hits_req;
        end else if (sc_fire) begin
            resv_d.armed = 1'b0;
        end else if (snoop_hits_resv) begin
            resv_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resv_q <= '0;
        end else begin
            resv_q <= resv_d;
        end
    end

    assign resv_valid = resv_q.armed;

endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(WORDS)-1:0] idx,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] cells [WORDS];

    assign rdata = cells[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                cells[i] <= '0;
            end
        end else if (we) begin
            cells[idx] <= wdata;
        end
    end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int GRAN_BITS = 2,
    parameter int MEM_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_sc_ok
);
    localparam int IDX_W = $clog2(MEM_WORDS);

    op_e               op;
    logic              ll_fire, sc_fire, st_fire, sc_pass, resv_valid, mem_we;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] mem_rdata;

    assign op      = op_e'(req_op);
    assign ll_fire = req_valid && (op == OP_LL);
    assign sc_fire = req_valid && (op == OP_SC);
    assign st_fire = req_valid && (op == OP_STORE);
    assign mem_we  = st_fire || sc_pass;
    assign idx     = req_addr[GRAN_BITS +: IDX_W];

    llsc_resv #(
        .ADDR_W    (ADDR_W),
        .GRAN_BITS (GRAN_BITS)
    ) u_resv (
        .clk        (clk),
        .rst        (rst),
        .ll_fire    (ll_fire),
        .sc_fire    (sc_fire),
        .req_addr   (req_addr),
        .snp_valid  (snp_valid),
        .snp_addr   (snp_addr),
        .resv_valid (resv_valid),
        .sc_pass    (sc_pass)
    );

    llsc_mem #(
        .DATA_W (DATA_W),
        .WORDS  (MEM_WORDS)
    ) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .idx   (idx),
        .wdata (req_wdata),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_sc_ok <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && op_returns_data(op)) ? mem_rdata : '0;
            rsp_sc_ok <= sc_pass;
        end
    end

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int ADDR_W    = 16,
    parameter int GRAN_BITS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              snp_valid,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              rsp_valid,
    input logic              rsp_sc_ok,
    input logic              resv_valid
);
    logic is_sc, snoop_same;
    assign is_sc      = req_valid && (req_op == 3'd4);
    assign snoop_same = snp_valid &&
        (snp_addr[ADDR_W-1:GRAN_BITS] == req_addr[ADDR_W-1:GRAN_BITS]);

    assert_resp_follows_req_R12: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_ok_only_for_sc_R12: assert property (@(posedge clk) disable iff (rst)
        !is_sc |=> !rsp_sc_ok);

    assert_reset_disarms_R10: assert property (@(posedge clk)
        rst |=> (!resv_valid && !rsp_valid));

    assert_sc_clears_R7: assert property (@(posedge clk) disable iff (rst)
        is_sc |=> !resv_valid);

    assert_unarmed_sc_fails_R4: assert property (@(posedge clk) disable iff (rst)
        (is_sc && !resv_valid) |=> !rsp_sc_ok);

    assert_snoop_beats_sc_R8: assert property (@(posedge clk) disable iff (rst)
        (is_sc && snoop_same) |=> !rsp_sc_ok);

    assert_ll_snoop_disarms_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd3 && snoop_same) |=> !resv_valid);

endmodule

bind llsc_monitor llsc_monitor_chk #(
    .ADDR_W    (ADDR_W),
    .GRAN_BITS (GRAN_BITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .snp_valid  (snp_valid),
    .snp_addr   (snp_addr),
    .rsp_valid  (rsp_valid),
    .rsp_sc_ok  (rsp_sc_ok),
    .resv_valid (resv_valid)
);

// File: tb/test_llsc_monitor.sv
`timescale 1ns/1ps
module test_llsc_monitor;
    import llsc_pkg::*;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int GB = 2;
    localparam int WORDS = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [2:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          snp_valid;
    logic [AW-1:0] snp_addr;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_sc_ok;

    always #10 clk = ~clk;

    llsc_monitor i_llsc_monitor (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .snp_valid(snp_valid),
        .snp_addr(snp_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_sc_ok(rsp_sc_ok)
    );

    // Behavioural reference state
    int unsigned mdl_mem [WORDS];
    bit          mdl_armed;
    int unsigned mdl_tag;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 0;

    function automatic int unsigned gran(input int unsigned a);
        return a >> GB;
    endfunction

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic check_cycle(input string tag, input bit ev, input int unsigned ed, input bit eok);
        n_checks++;
        if (rsp_valid !== ev || rsp_rdata !== ed || rsp_sc_ok !== eok) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b data=%h ok=%0b, expected valid=%0b data=%h ok=%0b",
                     tag, rsp_valid, rsp_rdata, rsp_sc_ok, ev, ed, eok);
        end
    endtask

    // One clock: drive at negedge, model the edge, compare at the next negedge
    task automatic step(input string tag, input op_e op, input int unsigned addr,
                        input int unsigned wd, input bit sv, input int unsigned sa);
        bit          ev, eok, sh_resv, sh_req;
        int unsigned ed, idx;
        req_valid = (op != OP_IDLE);
        req_op    = op;
        req_addr  = addr[AW-1:0];
        req_wdata = wd;
        snp_valid = sv;
        snp_addr  = sa[AW-1:0];
        idx       = (addr >> GB) % WORDS;
        sh_resv   = sv && gran(sa) == mdl_tag;
        sh_req    = sv && gran(sa) == gran(addr);
        ev  = (op != OP_IDLE);
        ed  = (op == OP_LOAD || op == OP_LL) ? mdl_mem[idx] : 0;
        eok = (op == OP_SC) && mdl_armed && mdl_tag == gran(addr) && !sh_resv;
        @(posedge clk);
        if (op == OP_STORE || eok) mdl_mem[idx] = wd;
        if (op == OP_LL) begin
            mdl_tag   = gran(addr);
            mdl_armed = !sh_req;
        end else if (op == OP_SC) begin
            mdl_armed = 0;
        end else if (sh_resv) begin
            mdl_armed = 0;
        end
        @(negedge clk);
        check_cycle(tag, ev, ed, eok);
        req_valid = 0; snp_valid = 0; req_op = OP_IDLE;
    endtask

    task automatic do_reset;
        rst = 1;
        req_valid = 0; req_op = OP_IDLE; req_addr = '0; req_wdata = '0;
        snp_valid = 0; snp_addr = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < WORDS; i++) mdl_mem[i] = 0;
        mdl_armed = 0;
        mdl_tag   = 0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            report();
        end
    end

    initial begin
        do_reset();
        check_cycle("R10 reset outputs", 0, 0, 0);
        step("R10 idle after reset", OP_IDLE, 0, 0, 0, 0);
        step("R10 SC after reset fails", OP_SC, 'h10, 'h99, 0, 0);

        step("R2 store", OP_STORE, 'h10, 'hA5A5_0001, 0, 0);
        step("R2 load", OP_LOAD, 'h10, 0, 0, 0);
        step("R1 LL read", OP_LL, 'h10, 0, 0, 0);
        step("R3 SC pass", OP_SC, 'h10, 'hB0B0_0002, 0, 0);
        step("R3 load after pass", OP_LOAD, 'h10, 0, 0, 0);
        step("R7 second SC fails", OP_SC, 'h10, 'hDEAD_0003, 0, 0);
        step("R4 no write after fail", OP_LOAD, 'h10, 0, 0, 0);

        step("R5 LL", OP_LL, 'h20, 0, 0, 0);
        step("R5 snoop other granule", OP_IDLE, 0, 0, 1, 'h24);
        step("R5 SC still passes", OP_SC, 'h20, 'h2222_0004, 0, 0);
        step("R9 LL", OP_LL, 'h20, 0, 0, 0);
        step("R9 snoop same word offset 2", OP_IDLE, 0, 0, 1, 'h22);
        step("R5 SC after snoop fails", OP_SC, 'h20, 'hBAD0_0005, 0, 0);
        step("R4 memory unchanged", OP_LOAD, 'h20, 0, 0, 0);

        step("R6 LL", OP_LL, 'h30, 0, 0, 0);
        step("R6 SC other granule fails", OP_SC, 'h34, 'hBAD0_0006, 0, 0);
        step("R7 SC after failed SC", OP_SC, 'h30, 'hBAD0_0007, 0, 0);
        step("R6 neighbour untouched", OP_LOAD, 'h34, 0, 0, 0);
        step("R9 LL", OP_LL, 'h30, 0, 0, 0);
        step("R9 SC offset 3 passes", OP_SC, 'h33, 'h3333_0008, 0, 0);
        step("R9 load", OP_LOAD, 'h30, 0, 0, 0);

        step("R8 LL", OP_LL, 'h40, 0, 0, 0);
        step("R8 SC with same-cycle snoop", OP_SC, 'h40, 'hBAD0_0009, 1, 'h41);
        step("R8 memory unchanged", OP_LOAD, 'h40, 0, 0, 0);
        step("R8 LL again", OP_LL, 'h40, 0, 0, 0);
        step("R8 SC with unrelated snoop", OP_SC, 'h40, 'h4444_000A, 1, 'h80);

        step("R10 LL first", OP_LL, 'h40, 0, 0, 0);
        step("R10 LL replaces", OP_LL, 'h50, 0, 0, 0);
        step("R10 SC old address fails", OP_SC, 'h40, 'hBAD0_000B, 0, 0);
        step("R10 LL", OP_LL, 'h50, 0, 0, 0);
        step("R10 SC new address", OP_SC, 'h50, 'h5555_000C, 0, 0);
        step("R10 LL address zero", OP_LL, 'h0, 0, 0, 0);
        step("R10 SC address zero", OP_SC, 'h0, 'h0000_ABCD, 0, 0);
        step("R10 load address zero", OP_LOAD, 'h0, 0, 0, 0);

        step("R11 LL with snoop", OP_LL, 'h60, 0, 1, 'h60);
        step("R11 SC fails", OP_SC, 'h60, 'hBAD0_000D, 0, 0);
        step("R2 LL", OP_LL, 'h60, 0, 0, 0);
        step("R2 own store keeps reservation", OP_STORE, 'h60, 'h6060_000E, 0, 0);
        step("R2 SC passes", OP_SC, 'h60, 'h6161_000F, 0, 0);
        step("R12 load returns SC data", OP_LOAD, 'h60, 0, 0, 0);

        step("R10 LL before reset", OP_LL, 'h70, 0, 0, 0);
        do_reset();
        check_cycle("R10 outputs after reset", 0, 0, 0);
        step("R10 SC after reset fails", OP_SC, 'h70, 'hBAD0_0010, 0, 0);
        step("R10 memory cleared", OP_LOAD, 'h70, 0, 0, 0);

        done = 1;
        report();
    end

endmodule